// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block turns a serial bit stream into parallel words. It runs entirely on the serial bit clock. On every rising edge it shifts one bit into a staging register. A free-running divide counter marks every sixteenth edge as a word boundary. On that edge the newest full word is copied into a parallel output register, and a one-cycle word-valid strobe and a divided-down parallel clock are raised.

The word framing can be moved with a synchronization input. The sync input must stay high for at least four bit clocks to count. When it does, the block drops exactly one incoming bit by holding its divide counter for one extra bit clock. That word period then lasts seventeen bit clocks, and every later word boundary moves one bit later in the stream. Each sync pulse causes one slip however long it is held. Framing logic upstream can therefore step through bit positions one pulse at a time until it finds its alignment pattern.

Word width, sync qualification length and bit order are parameters. The defaults give 16-bit words, first bit received in the most significant position, and a four-cycle qualification.

Top module: `sp_deser`

## Requirements
- R1: Each word on `pword` holds the sixteen most recent serial bits, including the bit sampled on the boundary edge. The earliest of these bits is on bit 15 and the latest is on bit 0.
- R2: After reset is released, `wvalid` is high after the 16th bit-clock edge and then after every 16th edge, when no slip is taken.
- R3: `wvalid` lasts exactly one bit clock, and `pword` changes only on a cycle where `wvalid` is high.
- R4: A sync pulse that is high for fewer than four consecutive bit clocks has no effect on word timing.
- R5: A sync pulse high for four or more bit clocks makes exactly one word period last 17 bit clocks. The bit at the start of that period is dropped, and the framing of later words moves one bit later.
- R6: The held bit-clock cycle of a slip falls no earlier than the fourth edge on which sync is high, and within 32 bit clocks of the first edge on which sync is high.
- R7: A sync pulse of any length gives at most one slip. Sync must go low before another pulse can arm a new slip.
- R8: While the synchronous active-high reset is applied, `pword` reads zero and `wvalid` and `pclk` read low.
- R9: `pclk` is high during the last eight bit clocks of each word period and falls in the cycle where `wvalid` is high. In a slipped period its low phase lasts one extra bit clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdin | input | 1 | Serial data bit |
| sync_in | input | 1 | Framing-slip request, qualified by length |
| pword | output | 16 | Parallel output word |
| wvalid | output | 1 | One-cycle strobe marking a new word |
| pclk | output | 1 | Parallel clock, bit clock divided by 16 |

## Verification
The bench builds the block with its defaults: 16-bit words, most significant bit first and four-cycle sync qualification. With these values a slip shows up as a 17-cycle gap between strobes. That puts the qualification edge directly in reach: pulses of three and four cycles differ by one cycle. Sync pulses are started at several offsets inside a word period, so the arm-to-boundary wait covers both short and long latencies.

// File: rtl/deser_pkg.sv
package deser_pkg;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } bit_order_e;

endpackage

// File: rtl/deser_shift.sv
module deser_shift
   import deser_pkg::*;
#(
   parameter int         W     = 16,
   parameter bit_order_e ORDER = ORDER_MSB_FIRST
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sdin,
   output logic [W-1:0] next_word
);

   localparam int KEEP = W - 1;

   logic [KEEP-1:0] stage;

   generate
      if (W < 4) begin : g_bad_width
         $error("deser_shift: W must be at least 4");
      end

      if (ORDER == ORDER_MSB_FIRST) begin : g_msb
         always_ff @(posedge clk) begin
            if (rst) stage <= '0;
            else     stage <= {stage[KEEP-2:0], sdin};
         end
         assign next_word = {stage, sdin};
      end else begin : g_lsb
         always_ff @(posedge clk) begin
            if (rst) stage <= '0;
            else     stage <= {sdin, stage[KEEP-1:1]};
         end
         assign next_word = {sdin, stage};
      end
   endgenerate

endmodule

// File: rtl/deser_divider.sv
module deser_divider #(
   parameter int W  = 16,
   localparam int CW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hold,
   output logic [CW-1:0] cnt,
   output logic          word_end,
   output logic          pclk
);

   localparam logic [CW-1:0] LAST = CW'(W - 1);

   generate
      if ((W & (W - 1)) != 0) begin : g_bad_pow2
         $error("deser_divider: W must be a power of two");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (!hold) cnt <= cnt + 1'b1;
   end

   assign word_end = (cnt == LAST);
   assign pclk     = cnt[CW-1];

   // R5: a held cycle leaves the counter where it was
   assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (rst)
      hold |=> (cnt == $past(cnt)));

   // R9: the parallel clock falls right after a word boundary
   assert_pclk_falls_R9: assert property (@(posedge clk) disable iff (rst)
      word_end |=> !pclk);

endmodule

// File: rtl/deser_syncq.sv
module deser_syncq #(
   parameter int SYNC_MIN = 4,
   localparam int RW = $clog2(SYNC_MIN + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic sync_in,
   input  logic take,
   output logic arm
);

   localparam logic [RW-1:0] RUN_MAX  = RW'(SYNC_MIN);
   localparam logic [RW-1:0] RUN_FIRE = RW'(SYNC_MIN - 1);

   logic [RW-1:0] run;
   logic          fire;

   generate
      if (SYNC_MIN < 1) begin : g_bad_min
         $error("deser_syncq: SYNC_MIN must be at least 1");
      end
   endgenerate

   assign fire = sync_in && (run == RUN_FIRE);

   always_ff @(posedge clk) begin
      if (rst)           run <= '0;
      else if (!sync_in) run <= '0;
      else if (run != RUN_MAX) run <= run + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)       arm <= 1'b0;
      else if (fire) arm <= 1'b1;
      else if (take) arm <= 1'b0;
   end

   // R4: arming needs sync seen high on the edge that armed it
   assert_arm_needs_sync_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(arm) |-> $past(sync_in));

   // R7: a slip that is taken disarms unless a new pulse qualifies at once
   assert_take_disarms_R7: assert property (@(posedge clk) disable iff (rst)
      (take && !fire) |=> !arm);

endmodule

// File: rtl/sp_deser.sv
module sp_deser
   import deser_pkg::*;
#(
   parameter int         WORD_W   = 16,
   parameter int         SYNC_MIN = 4,
   parameter bit_order_e ORDER    = ORDER_MSB_FIRST,
   localparam int        CW       = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sdin,
   input  logic              sync_in,
   output logic [WORD_W-1:0] pword,
   output logic              wvalid,
   output logic              pclk
);

   logic [WORD_W-1:0] next_word;
   logic [CW-1:0]     cnt;
   logic              word_end;
   logic              arm;
   logic              take;

   deser_shift #(.W(WORD_W), .ORDER(ORDER)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .sdin      (sdin),
      .next_word (next_word)
   );

   // slip is taken on the first cycle of a word period
   assign take = arm && (cnt == '0);

   deser_divider #(.W(WORD_W)) u_div (
      .clk      (clk),
      .rst      (rst),
      .hold     (take),
      .cnt      (cnt),
      .word_end (word_end),
      .pclk     (pclk)
   );

   deser_syncq #(.SYNC_MIN(SYNC_MIN)) u_syncq (
      .clk     (clk),
      .rst     (rst),
      .sync_in (sync_in),
      .take    (take),
      .arm     (arm)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pword  <= '0;
         wvalid <= 1'b0;
      end else begin
         wvalid <= word_end;
         if (word_end) pword <= next_word;
      end
   end

   // R3: the strobe never lasts two cycles
   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
      wvalid |=> !wvalid);

   // R3: the word only moves with a strobe
   assert_word_stable_R3: assert property (@(posedge clk) disable iff (rst)
      !wvalid |-> $stable(pword));

   // R9: the parallel clock is low while the strobe is high
   assert_pclk_low_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
      wvalid |-> !pclk);

endmodule

// File: tb/tb_sp_deser.sv
module tb_sp_deser;

   localparam int W   = 16;
   localparam int SQ  = 4;
   localparam logic [15:0] VEC [8] = '{
      16'h8000, 16'h0001, 16'hA5C3, 16'hFFFF,
      16'h0000, 16'h1234, 16'hF00F, 16'h7FFE
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sdin = 1'b0;
   logic          sync_in = 1'b0;
   logic [W-1:0]  pword;
   logic          wvalid;
   logic          pclk;

   int checks = 0;
   int fails  = 0;

   sp_deser dut (
      .clk     (clk),
      .rst     (rst),
      .sdin    (sdin),
      .sync_in (sync_in),
      .pword   (pword),
      .wvalid  (wvalid),
      .pclk    (pclk)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // requirement-level reference, advanced at each rising edge
   logic [W-1:0] hist = '0;
   logic [3:0]   mcnt = '0;
   int           mrun = 0;
   bit           marm = 0;
   int           ecnt = 0;
   bit           cap_rst = 1;
   bit           started = 0;
   logic [W-1:0] exp_pword = '0;
   bit           exp_wv = 0;
   bit           exp_pclk = 0;

   always @(posedge clk) begin
      bit take, endw, fire;
      started = 1;
      cap_rst = rst;
      if (rst) begin
         hist = '0; mcnt = '0; mrun = 0; marm = 0; ecnt = 0;
         exp_pword = '0; exp_wv = 0; exp_pclk = 0;
      end else begin
         hist = {hist[W-2:0], sdin};
         take = marm && (mcnt == 4'd0);
         endw = (mcnt == 4'd15);
         fire = sync_in && (mrun == SQ - 1);
         mrun = sync_in ? ((mrun < SQ) ? mrun + 1 : mrun) : 0;
         if (endw) exp_pword = hist;
         exp_wv = endw;
         if (!take) mcnt = mcnt + 4'd1;
         if (fire) marm = 1;
         else if (take) marm = 0;
         exp_pclk = mcnt[3];
         ecnt++;
      end
   end

   // port-level observation of strobe gaps
   bit phase1 = 1;
   int widx = 0;
   bit have_last = 0;
   int last_strobe = 0;
   int slips = 0;
   int hold_edge = -1;

   always @(negedge clk) begin
      if (started) begin
         if (cap_rst) begin
            chk(pword == '0 && !wvalid && !pclk, "R8 reset state",
                {pword, 14'b0, wvalid, pclk}, 32'h0);
            have_last = 0;
         end else begin
            chk(wvalid == exp_wv, "R2 strobe timing", wvalid, exp_wv);
            chk(pclk == exp_pclk, "R9 parallel clock", pclk, exp_pclk);
            if (exp_wv)
               chk(pword == exp_pword, "R1 word content", pword, exp_pword);
            else
               chk(pword == exp_pword, "R3 word held", pword, exp_pword);
            if (wvalid) begin
               if (phase1 && widx < 8) begin
                  chk(pword == VEC[widx], "R1 table word", pword, VEC[widx]);
                  widx++;
                  if (widx == 8) phase1 = 0;
               end
               if (have_last && (ecnt - 1 - last_strobe) == 17) begin
                  slips++;
                  hold_edge = last_strobe + 1;
               end
               have_last = 1;
               last_strobe = ecnt - 1;
            end
         end
      end
   end

   logic [15:0] lfsr = 16'hACE1;
   function automatic bit next_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic drive(input bit b, input bit s);
      @(negedge clk);
      rst = 1'b0;
      sdin = b;
      sync_in = s;
   endtask

   task automatic do_reset(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rst = 1'b1;
         sdin = next_rand();
         sync_in = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(next_rand(), 1'b0);
   endtask

   // returns edge index of the first sampled high sync
   task automatic pulse(input int len, output int s);
      s = ecnt;
      for (int i = 0; i < len; i++) drive(next_rand(), 1'b1);
      drive(next_rand(), 1'b0);
   endtask

   bit done = 0;
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int s;
      do_reset(4);

      // table walk: eight words, MSB first, no sync
      for (int k = 0; k < 8; k++)
         for (int b = W - 1; b >= 0; b--)
            drive(VEC[k][b], 1'b0);
      idle(20);
      chk(widx == 8, "R2 table words seen", widx, 8);

      // R4: three-cycle pulse is ignored
      slips = 0;
      pulse(SQ - 1, s);
      idle(70);
      chk(slips == 0, "R4 short sync no slip", slips, 0);

      // R5/R6: four-cycle pulses at several phases
      for (int off = 0; off < 16; off += 5) begin
         idle(off);
         slips = 0;
         hold_edge = -1;
         pulse(SQ, s);
         idle(60);
         chk(slips == 1, "R5 one slip", slips, 1);
         chk(hold_edge >= s + SQ && hold_edge <= s + 32, "R6 slip latency",
             hold_edge - s, 32);
      end

      // R7: long pulse gives one slip only
      slips = 0;
      pulse(70, s);
      idle(60);
      chk(slips == 1, "R7 long pulse single slip", slips, 1);

      // R7: rearmed after sync returns low
      slips = 0;
      pulse(SQ, s);
      idle(60);
      chk(slips == 1, "R7 rearm after low", slips, 1);

      // R8: reset in mid-stream, then normal framing resumes
      idle(7);
      do_reset(3);
      slips = 0;
      idle(80);
      chk(slips == 0, "R8 framing after reset", slips, 0);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule